// File: doc/BRIEF.md
# Dual-Gain AGC Loop Parameter Stage

This block is the control core of a digital automatic gain control loop. Software programs five loop parameters through a small register write port: the pole of the open-loop filter, the desired level, two loop gains and an error threshold. The parameters go to shadow registers, and the running loop does not see them at that point. An AGC initialize strobe copies all five into working registers and clears the loop accumulator in the same cycle. Loop behaviour therefore changes only at well-defined restart points.

For every signal-level estimate that arrives (an unsigned code in steps of 3/32 dB), the block forms a signed error: desired level minus measured level. It chooses a loop gain by comparing the error magnitude with the threshold. It then advances a first-order recursion, `acc = P*acc + K*error`, in fixed point with rounding and saturation. The accumulator is presented as the gain correction word, together with a one-cycle valid flag. The desired level can be used as a target signal level or as a target clipping level; the block treats both the same way. Power detection, the log conversion and the data-path multiplier sit outside this block.

Top module: `agc_dual_gain_loop`

## Requirements
- R1: After reset, gain_out is 0 and gain_valid is 0. All working parameters are 0, so a level sample taken before any initialize leaves gain_out at 0.
- R2: A write (wr_en high) with wr_sel 0 = pole P, 1 = desired level R, 2 = gain K1, 3 = gain K2, 4 = error threshold T stores wr_data in a shadow register. wr_sel codes 5 to 7 are ignored. The running loop keeps its working values until init is pulsed, and that pulse copies all five shadow values.
- R3: The error is the signed difference R minus lvl_in, in 3/32 dB codes (range -255 to +255).
- R4: When the error magnitude is less than or equal to T, the update uses K1.
- R5: When the error magnitude is greater than T, the update uses K2.
- R6: P and K are unsigned fractions code/256. The update is acc' = rnd(P*acc/256) + rnd(K*error*16/256). Here acc has 4 fractional bits, and rnd(x/256) = floor((x+128)/256).
- R7: The sum saturates to the signed 16-bit range, from -32768 to 32767.
- R8: In the cycle after init is high, gain_out is 0 and gain_valid is 0. A level sample presented in the same cycle as init is discarded.
- R9: gain_valid is high in exactly the cycle after a level sample is accepted, and gain_out shows the new value in that cycle. Without a sample, gain_out holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Parameter write strobe |
| wr_sel | input | 3 | Parameter select (0 P, 1 R, 2 K1, 3 K2, 4 T) |
| wr_data | input | 8 | Parameter value |
| init | input | 1 | AGC initialize: load working parameters, clear accumulator |
| lvl_valid | input | 1 | Level sample strobe |
| lvl_in | input | 8 | Measured level, 3/32 dB per code |
| gain_out | output | 16 | Signed gain correction word, 4 fractional bits |
| gain_valid | output | 1 | High for one cycle after each accepted sample |

## Verification
The bench programs new gains without an initialize and checks that the output still follows the old values. A design that let writes through directly would change the output at once. The threshold is probed at error magnitudes equal to T and one above it, for both signs of error. A comparator with the wrong sense, or one that ignores the sign, would pick the other gain and give a different accumulator value. Long runs at full-scale error drive the accumulator to both rails: a design without saturation wraps around to the opposite sign. A sample that arrives together with init must not leave any trace in the output.

// File: rtl/agc_loop_pkg.sv
package agc_loop_pkg;
  localparam int unsigned CW = 8;   // coefficient / parameter width
  localparam int unsigned LW = 8;   // level code width

  typedef enum logic [2:0] {
    SEL_POLE  = 3'd0,
    SEL_LEVEL = 3'd1,
    SEL_GAIN1 = 3'd2,
    SEL_GAIN2 = 3'd3,
    SEL_THRES = 3'd4
  } prm_sel_e;

  typedef struct packed {
    logic [CW-1:0] pole;
    logic [LW-1:0] level;
    logic [CW-1:0] gain1;
    logic [CW-1:0] gain2;
    logic [LW-1:0] thres;
  } prm_set_t;
endpackage

// File: rtl/agc_param_bank.sv
module agc_param_bank
  import agc_loop_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [CW-1:0]  wr_data,
  input  logic           init,
  output prm_set_t       work_o
);
  prm_set_t shadow_q, shadow_d;
  prm_set_t work_q, work_d;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) begin
      case (prm_sel_e'(wr_sel))
        SEL_POLE:  shadow_d.pole  = wr_data;
        SEL_LEVEL: shadow_d.level = wr_data;
        SEL_GAIN1: shadow_d.gain1 = wr_data;
        SEL_GAIN2: shadow_d.gain2 = wr_data;
        SEL_THRES: shadow_d.thres = wr_data;
        default:   shadow_d = shadow_q;
      endcase
    end
  end

  always_comb begin
    work_d = work_q;
    if (init) work_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      work_q   <= '0;
    end else begin
      shadow_q <= shadow_d;
      work_q   <= work_d;
    end
  end

  assign work_o = work_q;

  // R2: working parameters move only on an initialize
  a_r2_hold_params: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> $stable(work_q));
endmodule

// File: rtl/agc_gain_select.sv
module agc_gain_select
  import agc_loop_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LW-1:0]      level_ref,
  input  logic [LW-1:0]      level_meas,
  input  logic [LW-1:0]      thres,
  input  logic [CW-1:0]      gain1,
  input  logic [CW-1:0]      gain2,
  output logic signed [LW:0] err_o,
  output logic [CW-1:0]      gain_o
);
  logic signed [LW:0] err;
  logic [LW:0]        mag;
  logic               big_err;

  always_comb begin
    err     = $signed({1'b0, level_ref}) - $signed({1'b0, level_meas});
    mag     = err[LW] ? $unsigned(-err) : $unsigned(err);
    big_err = (mag > {1'b0, thres});
    gain_o  = big_err ? gain2 : gain1;
    err_o   = err;
  end

  // R4/R5: the gain handed on is always one of the two programmed gains
  a_r4_gain_member: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_o == gain1) || (gain_o == gain2));
endmodule

// File: rtl/agc_loop_core.sv
module agc_loop_core
  import agc_loop_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned FRAC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 sample,
  input  logic [CW-1:0]        pole,
  input  logic [CW-1:0]        gain,
  input  logic signed [LW:0]   err,
  output logic signed [AW-1:0] acc_o,
  output logic                 vld_o
);
  localparam int unsigned PPW = AW + CW + 1;          // pole product width
  localparam int unsigned EW  = LW + 1 + FRAC;        // scaled error width
  localparam int unsigned KPW = EW + CW + 1;          // gain product width
  localparam int unsigned SW  = AW + 2;               // sum width
  localparam logic signed [PPW-1:0] P_HALF = PPW'(1) <<< (CW-1);
  localparam logic signed [KPW-1:0] K_HALF = KPW'(1) <<< (CW-1);
  localparam logic signed [SW-1:0]  S_MAX  = SW'((1 << (AW-1)) - 1);
  localparam logic signed [SW-1:0]  S_MIN  = -(SW'(1) <<< (AW-1));

  logic signed [AW-1:0]  acc_q, acc_d;
  logic                  vld_q, vld_d;
  logic                  upd;
  logic signed [PPW-1:0] p_ext, a_ext, p_prod, p_rnd;
  logic signed [KPW-1:0] k_ext, e_ext, k_prod, k_rnd;
  logic signed [EW-1:0]  e_scl;
  logic signed [SW-1:0]  sum;

  assign upd = sample & ~init;

  always_comb begin
    p_ext  = $signed({{(AW+1){1'b0}}, pole});
    a_ext  = $signed({{(CW+1){acc_q[AW-1]}}, acc_q});
    p_prod = p_ext * a_ext;
    p_rnd  = (p_prod + P_HALF) >>> CW;

    e_scl  = $signed({err, {FRAC{1'b0}}});
    k_ext  = $signed({{(EW+1){1'b0}}, gain});
    e_ext  = $signed({{(CW+1){e_scl[EW-1]}}, e_scl});
    k_prod = k_ext * e_ext;
    k_rnd  = (k_prod + K_HALF) >>> CW;

    sum = $signed(p_rnd[SW-1:0]) + $signed(k_rnd[SW-1:0]);

    acc_d = acc_q;
    vld_d = 1'b0;
    if (init) begin
      acc_d = '0;
    end else if (upd) begin
      vld_d = 1'b1;
      if (sum > S_MAX)      acc_d = S_MAX[AW-1:0];
      else if (sum < S_MIN) acc_d = S_MIN[AW-1:0];
      else                  acc_d = sum[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      vld_q <= vld_d;
    end
  end

  assign acc_o = acc_q;
  assign vld_o = vld_q;

  // R8: initialize clears the accumulator and suppresses valid
  a_r8_init_clear: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (acc_q == '0) && !vld_q);
  // R9: valid only follows an accepted sample
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(sample && !init));
  // R9: without a sample or initialize the word holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample && !init) |=> $stable(acc_q));
endmodule

// File: rtl/agc_dual_gain_loop.sv
module agc_dual_gain_loop
  import agc_loop_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned FRAC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [7:0]           wr_data,
  input  logic                 init,
  input  logic                 lvl_valid,
  input  logic [7:0]           lvl_in,
  output logic signed [AW-1:0] gain_out,
  output logic                 gain_valid
);
  prm_set_t           work;
  logic signed [LW:0] err;
  logic [CW-1:0]      k_sel;

  agc_param_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .init    (init),
    .work_o  (work)
  );

  agc_gain_select u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_ref  (work.level),
    .level_meas (lvl_in),
    .thres      (work.thres),
    .gain1      (work.gain1),
    .gain2      (work.gain2),
    .err_o      (err),
    .gain_o     (k_sel)
  );

  agc_loop_core #(.AW(AW), .FRAC(FRAC)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (init),
    .sample (lvl_valid),
    .pole   (work.pole),
    .gain   (k_sel),
    .err    (err),
    .acc_o  (gain_out),
    .vld_o  (gain_valid)
  );
endmodule

// File: tb/agc_dual_gain_loop_tb.sv
module agc_dual_gain_loop_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic init = 1'b0;
  logic lvl_valid = 1'b0;
  logic [7:0] lvl_in = '0;
  logic signed [15:0] gain_out;
  logic gain_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  // bench-side model of the working parameters and accumulator
  int m_p = 0, m_r = 0, m_k1 = 0, m_k2 = 0, m_t = 0, m_acc = 0;
  int s_p = 0, s_r = 0, s_k1 = 0, s_k2 = 0, s_t = 0;

  always #4 clk = ~clk;

  agc_dual_gain_loop u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .init(init), .lvl_valid(lvl_valid),
    .lvl_in(lvl_in), .gain_out(gain_out), .gain_valid(gain_valid)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int step(input int acc, input int p, input int k, input int e);
    int pt, kt, s;
    pt = (p * acc + 128) >>> 8;
    kt = (k * e * 16 + 128) >>> 8;
    s  = pt + kt;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      0: s_p = val; 1: s_r = val; 2: s_k1 = val; 3: s_k2 = val; 4: s_t = val;
      default: ;
    endcase
  endtask

  task automatic do_init();
    @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    m_p = s_p; m_r = s_r; m_k1 = s_k1; m_k2 = s_k2; m_t = s_t; m_acc = 0;
    chk("R8 acc cleared", int'(gain_out), 0);
    chk("R8 valid low", int'(gain_valid), 0);
  endtask

  // present one sample; check valid and value one cycle later
  task automatic sample(input int lvl, input string req);
    int e, k, mag;
    @(negedge clk);
    lvl_valid = 1'b1; lvl_in = 8'(lvl);
    @(negedge clk);
    lvl_valid = 1'b0;
    e = m_r - lvl;
    mag = (e < 0) ? -e : e;
    k = (mag <= m_t) ? m_k1 : m_k2;
    m_acc = step(m_acc, m_p, k, e);
    chk({req, " value"}, int'(gain_out), m_acc);
    chk("R9 valid after sample", int'(gain_valid), 1);
  endtask

  task automatic t_reset();
    chk("R1 reset gain", int'(gain_out), 0);
    chk("R1 reset valid", int'(gain_valid), 0);
    sample(3, "R1 zero params");
    chk("R1 no gain before init", int'(gain_out), 0);
  endtask

  task automatic t_shadow();
    wr(0, 0); wr(1, 100); wr(2, 255); wr(3, 255); wr(4, 255);
    sample(50, "R2 writes not yet live");
    chk("R2 output unchanged", int'(gain_out), 0);
    wr(7, 9); wr(5, 200);  // ignored codes
    do_init();
    sample(95, "R3 positive error");
    sample(105, "R3 negative error");
    chk("R2 K1 live after init", int'(gain_out), step(step(0,0,255,5),0,255,-5));
    wr(2, 16);  // change K1 without init
    sample(95, "R2 old K1 still used");
    chk("R2 old K1 value", int'(gain_out), step(m_acc, 0, 255, 5) == m_acc ? m_acc : m_acc);
  endtask

  task automatic t_threshold();
    wr(0, 0); wr(1, 100); wr(2, 32); wr(3, 200); wr(4, 10);
    do_init();
    sample(90, "R4 mag equal threshold");
    chk("R4 K1 at equal", int'(gain_out), step(0, 0, 32, 10));
    sample(89, "R5 mag above threshold");
    chk("R5 K2 above", int'(gain_out), step(0, 0, 200, 11));
    sample(111, "R5 negative above threshold");
    chk("R5 K2 negative", int'(gain_out), step(0, 0, 200, -11));
    sample(110, "R4 negative equal threshold");
    chk("R4 K1 negative", int'(gain_out), step(0, 0, 32, -10));
  endtask

  task automatic t_pole();
    wr(0, 200); wr(1, 120); wr(2, 77); wr(3, 150); wr(4, 20);
    do_init();
    sample(100, "R6 pole run");
    sample(110, "R6 pole run");
    sample(140, "R6 pole run");
    sample(121, "R6 pole run");
    sample(60,  "R6 pole run");
    repeat (3) @(negedge clk);
    chk("R9 hold without sample", int'(gain_out), m_acc);
    chk("R9 valid idle", int'(gain_valid), 0);
  endtask

  task automatic t_saturate();
    wr(0, 255); wr(1, 255); wr(2, 255); wr(3, 255); wr(4, 0);
    do_init();
    for (int i = 0; i < 16; i++) sample(0, "R7 positive drive");
    chk("R7 upper rail", int'(gain_out), 32767);
    wr(1, 0);
    do_init();
    for (int i = 0; i < 16; i++) sample(255, "R7 negative drive");
    chk("R7 lower rail", int'(gain_out), -32768);
  endtask

  task automatic t_init_collide();
    wr(0, 100); wr(1, 200); wr(2, 128); wr(3, 128); wr(4, 255);
    do_init();
    sample(20, "R8 pre-collision");
    @(negedge clk);
    init = 1'b1; lvl_valid = 1'b1; lvl_in = 8'd0;
    @(negedge clk);
    init = 1'b0; lvl_valid = 1'b0;
    m_acc = 0;
    chk("R8 sample with init discarded", int'(gain_out), 0);
    chk("R8 no valid on collision", int'(gain_valid), 0);
    sample(180, "R8 restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_threshold();
    t_pole();
    t_saturate();
    t_init_collide();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule